// File: doc/BRIEF.md
# Cascadable Fall-Through Dual-Clock FIFO Chain

This block is a dual-clock FIFO that always presents its oldest stored word on the read data output without waiting for a read request. A stage reports "word available" and "space available" on two active-low ready outputs. Because of this, stages connect in series with no glue logic:

- A stage's output-ready drives the next stage's write enable.
- The next stage's input-ready drives that stage's read enable.
- Data passes straight across from one stage to the next.

The top module builds such a chain from a parameterised number of identical stages. Its outer ports behave like a single deeper FIFO.

Each stage moves pointers across clock domains as Gray codes through two-flop synchronisers. The links between stages run on a transfer clock. A parameter selects whether that clock is the outer write clock or the outer read clock. The chosen clock should be the faster of the two.

Timing in an empty chain: the first word written reaches the output after a fixed number of edges, which grows by four per extra stage. Timing in a full chain: after one read, the freed slot reaches the input after a fixed number of edges, which grows by three per extra stage.

A master reset empties every stage asynchronously.

Top module: `cfwft_chain`

## Requirements
- R1: While `mrst_n` is low, asynchronously and without a clock edge, the outputs are set as follows: `out_rdy_n` is 1, `in_rdy_n` is 0, `rd_data` is 0. After reset is released, no word stored before the reset ever appears.
- R2: The oldest stored word appears on `rd_data` with `out_rdy_n` = 0 without any read request. Both hold unchanged on every `rd_clk` edge where `rd_en_n` is 1.
- R3: A read happens at a `rd_clk` edge with `rd_en_n` = 0 and `out_rdy_n` = 0. Words leave in exactly the order they were accepted.
- R4: A write is accepted at a `wr_clk` edge with `wr_en_n` = 0 and `in_rdy_n` = 0. A write attempted while `in_rdy_n` = 1 adds nothing. While `wr_en_n` = 1, `in_rdy_n` never goes from 0 to 1.
- R5: A read attempted while `out_rdy_n` = 1 has no effect. `rd_data` changes only together with `out_rdy_n` going to 0.
- R6: Each stage holds `DEPTH`+1 words: `DEPTH` in its array plus one in its output register. The chain accepts exactly `STAGES`*(`DEPTH`+1) words before `in_rdy_n` stays at 1.
- R7: In an empty chain with all clocks identical, `out_rdy_n` goes to 0 on the (`STAGES`-1)*4+3-th edge after the edge that wrote the first word.
- R8: In a full chain with all clocks identical, a single read makes `in_rdy_n` go to 0 on the (`STAGES`-1)*3+2-th edge after the read edge.
- R9: When the last stage still holds further words, the word after a read appears at the read edge itself, with `out_rdy_n` staying 0. There is no ripple delay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Write clock of the first stage |
| rd_clk | input | 1 | Read clock of the last stage |
| mrst_n | input | 1 | Asynchronous active-low master reset |
| wr_en_n | input | 1 | Active-low write request |
| wr_data | input | WIDTH | Word to write |
| in_rdy_n | output | 1 | Active-low: at least one free location |
| rd_en_n | input | 1 | Active-low read request |
| rd_data | output | WIDTH | Oldest stored word (fall-through) |
| out_rdy_n | output | 1 | Active-low: `rd_data` holds a valid word |

## Verification
The hardest state to reach from the ports is a chain that is full in every stage at once, which the bubble latency needs. Data only reaches the later stages after rippling through the earlier ones.

The stimulus therefore keeps the write request asserted until input-ready has stayed high for many cycles. Writes keep being attempted during that time, and they must be dropped. The stimulus then issues one read and counts edges until input-ready returns.

The ripple latency is measured the same way from a single write into an empty chain. Random phases, one write-heavy and one read-heavy, then drive the chain repeatedly through its full and empty edges.

// File: rtl/cfwft_pkg.sv
package cfwft_pkg;

   // which outer clock drives the links between stages
   typedef enum bit {
      XFER_WR_CLK = 1'b0,
      XFER_RD_CLK = 1'b1
   } cfwft_xfer_e;

   function automatic bit is_pow2(input int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/cfwft_sync.sv
module cfwft_sync #(
   parameter int unsigned W = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] meta_r;
   logic [W-1:0] sync_r;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         meta_r <= '0;
         sync_r <= '0;
      end else begin
         meta_r <= d;
         sync_r <= meta_r;
      end
   end

   assign q = sync_r;
endmodule

// File: rtl/cfwft_wr_ctl.sv
module cfwft_wr_ctl #(
   parameter int unsigned AW = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wen_n,
   input  logic [AW:0]   rgray_s,
   output logic          ir_n,
   output logic          we,
   output logic [AW-1:0] waddr,
   output logic [AW:0]   wgray
);
   logic [AW:0] wbin;
   logic [AW:0] wbin_nx;
   logic        full;

   // full: write Gray pointer equals read pointer with top two bits flipped
   assign full    = (wgray == {~rgray_s[AW -: 2], rgray_s[AW-2:0]});
   assign we      = !wen_n && !full;
   assign wbin_nx = wbin + 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wbin  <= '0;
         wgray <= '0;
      end else if (we) begin
         wbin  <= wbin_nx;
         wgray <= wbin_nx ^ (wbin_nx >> 1);
      end
   end

   assign ir_n  = full;
   assign waddr = wbin[AW-1:0];
endmodule

// File: rtl/cfwft_rd_ctl.sv
module cfwft_rd_ctl #(
   parameter int unsigned AW = 2,
   parameter int unsigned W  = 9
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ren_n,
   input  logic [AW:0]   wgray_s,
   input  logic [W-1:0]  mem_q,
   output logic [AW-1:0] raddr,
   output logic [AW:0]   rgray,
   output logic          or_n,
   output logic [W-1:0]  q
);
   logic [AW:0] rbin;
   logic [AW:0] rbin_nx;
   logic        head_vld;
   logic        arr_empty;
   logic        take;
   logic        load;

   assign arr_empty = (rgray == wgray_s);
   assign take      = !ren_n && head_vld;
   // refill the head register whenever it is free or being consumed
   assign load      = !arr_empty && (!head_vld || take);
   assign rbin_nx   = rbin + 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rbin     <= '0;
         rgray    <= '0;
         head_vld <= 1'b0;
         q        <= '0;
      end else if (load) begin
         q        <= mem_q;
         rbin     <= rbin_nx;
         rgray    <= rbin_nx ^ (rbin_nx >> 1);
         head_vld <= 1'b1;
      end else if (take) begin
         head_vld <= 1'b0;
      end
   end

   assign raddr = rbin[AW-1:0];
   assign or_n  = !head_vld;
endmodule

// File: rtl/cfwft_stage.sv
module cfwft_stage #(
   parameter int unsigned W     = 9,
   parameter int unsigned DEPTH = 4
) (
   input  logic         wclk,
   input  logic         rclk,
   input  logic         rst_n,
   input  logic         wen_n,
   input  logic [W-1:0] din,
   output logic         ir_n,
   input  logic         ren_n,
   output logic [W-1:0] dout,
   output logic         or_n
);
   localparam int unsigned AW = $clog2(DEPTH);

   logic [W-1:0]  mem [DEPTH];
   logic          we;
   logic [AW-1:0] waddr;
   logic [AW-1:0] raddr;
   logic [AW:0]   wgray;
   logic [AW:0]   rgray;
   logic [AW:0]   wgray_s;
   logic [AW:0]   rgray_s;

   always_ff @(posedge wclk) begin
      if (we) mem[waddr] <= din;
   end

   cfwft_sync #(.W(AW + 1)) u_w2r (
      .clk(rclk), .rst_n(rst_n), .d(wgray), .q(wgray_s)
   );

   cfwft_sync #(.W(AW + 1)) u_r2w (
      .clk(wclk), .rst_n(rst_n), .d(rgray), .q(rgray_s)
   );

   cfwft_wr_ctl #(.AW(AW)) u_wr (
      .clk(wclk), .rst_n(rst_n), .wen_n(wen_n), .rgray_s(rgray_s),
      .ir_n(ir_n), .we(we), .waddr(waddr), .wgray(wgray)
   );

   cfwft_rd_ctl #(.AW(AW), .W(W)) u_rd (
      .clk(rclk), .rst_n(rst_n), .ren_n(ren_n), .wgray_s(wgray_s),
      .mem_q(mem[raddr]), .raddr(raddr), .rgray(rgray),
      .or_n(or_n), .q(dout)
   );
endmodule

// File: rtl/cfwft_chain.sv
module cfwft_chain
   import cfwft_pkg::*;
#(
   parameter int unsigned WIDTH    = 9,
   parameter int unsigned DEPTH    = 4,
   parameter int unsigned STAGES   = 3,
   parameter cfwft_xfer_e XFER_SRC = XFER_RD_CLK
) (
   input  logic             wr_clk,
   input  logic             rd_clk,
   input  logic             mrst_n,
   input  logic             wr_en_n,
   input  logic [WIDTH-1:0] wr_data,
   output logic             in_rdy_n,
   input  logic             rd_en_n,
   output logic [WIDTH-1:0] rd_data,
   output logic             out_rdy_n
);
   localparam int unsigned LAST = STAGES - 1;

   if (!is_pow2(DEPTH) || DEPTH < 4) begin : g_bad_depth
      $error("cfwft_chain: DEPTH must be a power of two, at least 4");
   end
   if (STAGES < 1) begin : g_bad_stages
      $error("cfwft_chain: STAGES must be at least 1");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("cfwft_chain: WIDTH must be at least 1");
   end

   logic             xfer_clk;
   logic [WIDTH-1:0] st_q   [STAGES];
   logic [STAGES-1:0] st_or_n;
   logic [STAGES-1:0] st_ir_n;

   if (XFER_SRC == XFER_RD_CLK) begin : g_xfer_rd
      assign xfer_clk = rd_clk;
   end else begin : g_xfer_wr
      assign xfer_clk = wr_clk;
   end

   for (genvar k = 0; k < STAGES; k++) begin : g_stage
      logic             s_wclk;
      logic             s_rclk;
      logic             s_wen_n;
      logic             s_ren_n;
      logic [WIDTH-1:0] s_din;

      if (k == 0) begin : g_head
         assign s_wclk  = wr_clk;
         assign s_wen_n = wr_en_n;
         assign s_din   = wr_data;
      end else begin : g_link_in
         assign s_wclk  = xfer_clk;
         assign s_wen_n = st_or_n[k-1];
         assign s_din   = st_q[k-1];
      end

      if (k == LAST) begin : g_tail
         assign s_rclk  = rd_clk;
         assign s_ren_n = rd_en_n;
      end else begin : g_link_out
         assign s_rclk  = xfer_clk;
         assign s_ren_n = st_ir_n[k+1];
      end

      cfwft_stage #(.W(WIDTH), .DEPTH(DEPTH)) u_stage (
         .wclk (s_wclk),
         .rclk (s_rclk),
         .rst_n(mrst_n),
         .wen_n(s_wen_n),
         .din  (s_din),
         .ir_n (st_ir_n[k]),
         .ren_n(s_ren_n),
         .dout (st_q[k]),
         .or_n (st_or_n[k])
      );
   end

   assign in_rdy_n  = st_ir_n[0];
   assign out_rdy_n = st_or_n[LAST];
   assign rd_data   = st_q[LAST];
endmodule

// File: rtl/cfwft_chain_chk.sv
module cfwft_chain_chk #(
   parameter int unsigned WIDTH = 9
) (
   input logic             wr_clk,
   input logic             rd_clk,
   input logic             mrst_n,
   input logic             wr_en_n,
   input logic             rd_en_n,
   input logic             in_rdy_n,
   input logic             out_rdy_n,
   input logic [WIDTH-1:0] rd_data
);
   always @(posedge rd_clk) begin
      if (!mrst_n) begin
         AST_RESET_STATE: assert (out_rdy_n && !in_rdy_n && rd_data == '0); // R1
      end
   end

   AST_HEAD_HOLDS: assert property (@(posedge rd_clk) disable iff (!mrst_n)
      (!out_rdy_n && rd_en_n) |=> (!out_rdy_n && $stable(rd_data))); // R2

   AST_IDLE_DATA_STILL: assert property (@(posedge rd_clk) disable iff (!mrst_n)
      out_rdy_n |=> ($stable(rd_data) || !out_rdy_n)); // R5

   AST_SPACE_KEPT: assert property (@(posedge wr_clk) disable iff (!mrst_n)
      (!in_rdy_n && wr_en_n) |=> !in_rdy_n); // R4
endmodule

bind cfwft_chain cfwft_chain_chk #(.WIDTH(WIDTH)) u_chk (
   .wr_clk   (wr_clk),
   .rd_clk   (rd_clk),
   .mrst_n   (mrst_n),
   .wr_en_n  (wr_en_n),
   .rd_en_n  (rd_en_n),
   .in_rdy_n (in_rdy_n),
   .out_rdy_n(out_rdy_n),
   .rd_data  (rd_data)
);

// File: tb/cfwft_chain_tb_top.sv
`timescale 1ns/1ps
module cfwft_chain_tb_top;
   localparam int unsigned WIDTH  = 9;
   localparam int unsigned DEPTH  = 4;
   localparam int unsigned STAGES = 3;
   localparam int CAP = STAGES * (DEPTH + 1);
   localparam int RIP = (STAGES - 1) * 4 + 3;
   localparam int BUB = (STAGES - 1) * 3 + 2;

   logic             clk = 1'b0;
   logic             mrst_n = 1'b1;
   logic             wr_en_n = 1'b1;
   logic             rd_en_n = 1'b1;
   logic [WIDTH-1:0] wr_data = '0;
   logic             in_rdy_n;
   logic             out_rdy_n;
   logic [WIDTH-1:0] rd_data;

   int checks = 0;
   int failures = 0;
   int cyc = 0;
   bit done = 1'b0;
   logic [WIDTH-1:0] sb [$];

   always #2.5 clk = ~clk;   // 200 MHz

   cfwft_chain #(.WIDTH(WIDTH), .DEPTH(DEPTH), .STAGES(STAGES)) dut_i (
      .wr_clk(clk), .rd_clk(clk), .mrst_n(mrst_n),
      .wr_en_n(wr_en_n), .wr_data(wr_data), .in_rdy_n(in_rdy_n),
      .rd_en_n(rd_en_n), .rd_data(rd_data), .out_rdy_n(out_rdy_n)
   );

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // driver: applies inputs for the coming edge, records accepted writes
   task automatic drive(input bit wr, input bit rd, input logic [WIDTH-1:0] d);
      wr_en_n = !wr;
      rd_en_n = !rd;
      wr_data = d;
      if (!wr_en_n && !in_rdy_n) sb.push_back(wr_data);
   endtask

   // monitor: pops and compares whenever the coming edge performs a read
   task automatic monitor();
      logic [WIDTH-1:0] exp;
      if (!rd_en_n && !out_rdy_n) begin
         if (sb.size() == 0) begin
            check(1'b0, "R3 read with empty scoreboard", int'(rd_data), -1);
         end else begin
            exp = sb.pop_front();
            check(rd_data == exp, "R3 output order", int'(rd_data), int'(exp));
         end
      end
   endtask

   task automatic drain();
      int idle = 0;
      for (int i = 0; i < 3000 && idle < 40; i++) begin
         @(negedge clk);
         drive(1'b0, 1'b1, '0);
         monitor();
         if (out_rdy_n) idle++; else idle = 0;
      end
      @(negedge clk);
      drive(1'b0, 1'b0, '0);
      check(sb.size() == 0, "R4 no extra or lost words after drain", sb.size(), 0);
      check(out_rdy_n == 1'b1, "R3 empty after drain", int'(out_rdy_n), 1);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin : main
      int lat;
      int acc;
      int hi;
      #1 mrst_n = 1'b0;
      repeat (3) @(negedge clk);
      check(out_rdy_n == 1'b1, "R1 reset out_rdy_n", int'(out_rdy_n), 1);
      check(in_rdy_n == 1'b0, "R1 reset in_rdy_n", int'(in_rdy_n), 0);
      check(rd_data == '0, "R1 reset rd_data", int'(rd_data), 0);
      mrst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R5: reads on an empty chain do nothing
      rd_en_n = 1'b0;
      repeat (4) @(negedge clk);
      rd_en_n = 1'b1;
      check(out_rdy_n == 1'b1, "R5 read on empty ignored", int'(out_rdy_n), 1);
      check(rd_data == '0, "R5 rd_data untouched", int'(rd_data), 0);

      // R7: first-word ripple latency
      wr_data = 9'h1A5;
      wr_en_n = 1'b0;
      @(posedge clk);
      @(negedge clk);
      wr_en_n = 1'b1;
      lat = 0;
      for (int k = 1; k <= 30; k++) begin
         @(posedge clk);
         #1;
         if (lat == 0 && !out_rdy_n) lat = k;
      end
      check(lat == RIP, "R7 ripple latency", lat, RIP);
      check(rd_data == 9'h1A5, "R2 head word without read", int'(rd_data), 'h1A5);
      @(negedge clk);
      check(rd_data == 9'h1A5 && !out_rdy_n, "R2 head held with no read", int'(rd_data), 'h1A5);
      rd_en_n = 1'b0;
      @(posedge clk);
      #1;
      check(out_rdy_n == 1'b1, "R3 read removes only word", int'(out_rdy_n), 1);
      @(negedge clk);
      rd_en_n = 1'b1;

      // R6 / R4: fill to capacity with writes held on even while full
      acc = 0;
      hi = 0;
      for (int i = 0; i < 2000 && hi < 40; i++) begin
         @(negedge clk);
         cyc++;
         drive(1'b1, 1'b0, WIDTH'(cyc * 7 + 3));
         if (!in_rdy_n) begin
            acc++;
            hi = 0;
         end else begin
            hi++;
         end
      end
      check(acc == CAP, "R6 chain capacity", acc, CAP);

      // R9 and R8: one read from the full chain
      @(negedge clk);
      drive(1'b0, 1'b1, '0);
      monitor();
      @(posedge clk);
      #1;
      check(out_rdy_n == 1'b0, "R9 next word without delay", int'(out_rdy_n), 0);
      check(sb.size() > 0 && rd_data == sb[0], "R9 next word value", int'(rd_data),
            (sb.size() > 0) ? int'(sb[0]) : -1);
      @(negedge clk);
      drive(1'b0, 1'b0, '0);
      lat = 0;
      for (int k = 1; k <= 30; k++) begin
         @(posedge clk);
         #1;
         if (lat == 0 && !in_rdy_n) lat = k;
      end
      check(lat == BUB, "R8 bubble latency", lat, BUB);
      drain();

      // random phases through full and empty boundaries
      for (int ph = 0; ph < 2; ph++) begin
         for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            drive((ph == 0) ? ($urandom_range(3) != 0) : ($urandom_range(3) == 0),
                  (ph == 0) ? ($urandom_range(3) == 0) : ($urandom_range(3) != 0),
                  WIDTH'($urandom));
            monitor();
         end
      end
      drain();

      // R1: asynchronous reset with words stored
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         drive(1'b1, 1'b0, WIDTH'(i + 40));
      end
      @(negedge clk);
      drive(1'b0, 1'b0, '0);
      repeat (20) @(negedge clk);
      check(out_rdy_n == 1'b0, "R1 words present before reset", int'(out_rdy_n), 0);
      #1.2 mrst_n = 1'b0;
      #0.5;
      check(out_rdy_n == 1'b1 && in_rdy_n == 1'b0 && rd_data == '0,
            "R1 asynchronous reset", int'(out_rdy_n), 1);
      sb.delete();
      repeat (2) @(negedge clk);
      mrst_n = 1'b1;
      repeat (30) @(negedge clk);
      check(out_rdy_n == 1'b1, "R1 chain empty after reset", int'(out_rdy_n), 1);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule